// File: doc/BRIEF.md
# I2C Target with General-Call Software Reset

This block is the serial control port of a small peripheral. It watches an open-drain two-wire bus through an oversampling system clock, finds start, repeated-start and stop conditions, and takes part in transfers addressed to it. Write transfers load a small file of 16-bit registers through a byte-wide pointer. Read transfers return the register the pointer selects. The target drives the data line low through an output-enable and never drives it high.

The 7-bit device address is a fixed 6-bit prefix followed by one strap input as its lowest bit. The block also answers the bus-wide general-call address. When the first data byte after a general call is the reset code, the block clears its registers and pointer. It also emits a one-clock pulse that the rest of the peripheral can use as its software reset.

Top module: `i2c_tgt_gcreset`

## Requirements
- R1: After `rst_n` is low, `sda_oe` and `soft_rst_pulse` are 0 and every register reads 0x0000. The output `sda_oe` is 0 whenever the target is idle.
- R2: `sda_oe` changes only while SCL is low. The target pulls the line low (`sda_oe`=1) and otherwise releases it, and never drives it high.
- R3: The address byte is acknowledged (SDA low on the ninth clock) when bits 7:1 equal {DEV_ADDR_HI, addr_sel} (default 0x48 for addr_sel=0, 0x49 for addr_sel=1). Bit 0 is the R/W bit, where 1 means read. Any other address is not acknowledged and ignored until the next start, and this includes a 10-bit header 11110xx.
- R4: The address byte 0x00 (general call, write) is acknowledged. The byte 0x01 (general call with read) is not acknowledged.
- R5: In a write, the first data byte sets the pointer. Each later pair of bytes is written MSB first into the register the pointer selects, and a second pair overwrites the same register. Every data byte is acknowledged.
- R6: A pointer value of NUM_REGS or more (default 4) drops writes and reads as 0x0000.
- R7: A read returns the selected register MSB first, then LSB, then MSB again, for as long as the controller acknowledges. After a not-acknowledge the target releases SDA and goes idle.
- R8: A repeated start restarts address reception without a stop, and a pointer set before it selects the register for the read that follows.
- R9: After a general call, a first data byte of 0x06 raises `soft_rst_pulse` for exactly one clock. The pulse comes after the SCL falling edge that ends that byte's acknowledge, and it clears all registers and the pointer to 0.
- R10: After a general call, a first data byte other than 0x06 is acknowledged, raises no pulse and changes no register.
- R11: A stop (SDA rising while SCL is high) returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 1 | Strap that sets the lowest device-address bit |
| sda_oe | output | 1 | 1 pulls the data line low |
| soft_rst_pulse | output | 1 | One-clock software-reset pulse |

## Verification
The assertions check on every cycle that the data-line drive moves only while SCL is low and that it is released when the target is idle, while it waits for the controller's acknowledge, and after a stop. They also check that the reset pulse lasts one clock, appears with SCL low, and directly follows an acknowledge slot. Address matching, the pointer-then-pair write order, out-of-range pointers, read wrap-around, the repeated-start pointer hand-off, and the difference between reset and non-reset general-call bytes are shown only by the bench. It drives full bus transfers and reads the results back over the bus.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the I2C target.
// Assumes registers are two bytes wide and transferred most-significant byte first.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,  // waiting for a start
        ST_RX,    // shifting in a byte from the controller
        ST_ACK,   // holding our acknowledge on the ninth clock
        ST_TX,    // shifting out a byte to the controller
        ST_MACK   // ninth clock of a read: controller acknowledges or not
    } tgt_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,  // next received byte is the address
        PH_PTR,   // next received byte is the register pointer
        PH_MSB,   // next received byte is a register high byte
        PH_LSB    // next received byte is a register low byte
    } rx_phase_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Synchroniser and bus-condition detector.
// Brings SCL and SDA into the clk domain through STAGES flops and keeps one
// more flop of history. From that it flags SCL edges, starts (SDA falls with
// SCL high) and stops (SDA rises with SCL high). Assumes the bus is idle-high.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_sh, sda_sh;
    logic scl_now, scl_old, sda_old;

    // Shift both lines through the synchroniser chain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
            sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
        end
    end

    // Decode edges and bus conditions from the synchronised samples.
    always_comb begin
        scl_now   = scl_sh[STAGES-1];
        scl_old   = scl_sh[STAGES];
        sda_s     = sda_sh[STAGES-1];
        sda_old   = sda_sh[STAGES];
        scl_rise  = scl_now & ~scl_old;
        scl_fall  = ~scl_now & scl_old;
        start_det = scl_now & scl_old & sda_old & ~sda_s;
        stop_det  = scl_now & scl_old & ~sda_old & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_regs.sv
// Register file behind the bus port.
// NUM_REGS registers of REG_W bits, written one whole word per strobe.
// An index outside the file drops writes and reads as zero. A clear input
// resets every register in one cycle.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0] rd_idx,
    output logic [REG_W-1:0]  rd_data
);
    logic [REG_W-1:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // One storage word, cleared by reset or soft clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                mem[i] <= '0;
            else if (wr_en && wr_idx == BYTE_W'(i))
                mem[i] <= wr_data;
        end
    end

    // Read mux; out-of-range index returns zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == BYTE_W'(i))
                rd_data = mem[i];
    end
endmodule

// File: rtl/i2c_tgt_gcreset.sv
// I2C target with 7-bit addressing and a general-call software reset.
// A byte/bit state machine runs on the synchronised SCL edges. It changes
// the SDA drive only at SCL falling edges and samples at SCL rising edges.
// Assumes the SCL low time spans several clk cycles and that there is no
// clock stretching.
module i2c_tgt_gcreset
    import i2c_tgt_pkg::*;
#(
    parameter int          NUM_REGS    = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [5:0]  DEV_ADDR_HI = 6'b100100,
    parameter logic [7:0]  GC_RESET    = 8'h06
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel,
    output logic sda_oe,
    output logic soft_rst_pulse
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_t        st_q;
    rx_phase_t         ph_q;
    logic [3:0]        cnt_q;
    logic [BYTE_W-1:0] rx_sh, tx_sh, ptr_q, msb_q;
    logic              is_read, is_gc, gc_hit, rd_lsb, mack_q;
    logic              wr_stb;
    logic [REG_W-1:0]  wr_word, rd_data;
    logic [BYTE_W-1:0] next_tx;
    logic [6:0]        dev_addr;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst_pulse),
        .wr_en(wr_stb), .wr_idx(ptr_q), .wr_data(wr_word),
        .rd_idx(ptr_q), .rd_data(rd_data)
    );

    // Device address and the byte to send after a controller acknowledge.
    always_comb begin
        dev_addr = {DEV_ADDR_HI, addr_sel};
        next_tx  = rd_lsb ? rd_data[BYTE_W-1:0] : rd_data[REG_W-1:BYTE_W];
    end

    // Bus protocol state machine, register pointer and write staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;  ph_q <= PH_ADDR;  cnt_q <= '0;
            rx_sh <= '0;  tx_sh <= '0;  ptr_q <= '0;  msb_q <= '0;
            is_read <= 1'b0;  is_gc <= 1'b0;  gc_hit <= 1'b0;
            rd_lsb <= 1'b0;  mack_q <= 1'b0;  wr_stb <= 1'b0;
            wr_word <= '0;  sda_oe <= 1'b0;  soft_rst_pulse <= 1'b0;
        end else begin
            wr_stb         <= 1'b0;
            soft_rst_pulse <= 1'b0;
            if (stop_det) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                st_q   <= ST_RX;
                ph_q   <= PH_ADDR;
                cnt_q  <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st_q)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall && cnt_q == LAST_BIT) begin
                            if (ph_q == PH_ADDR) begin
                                if (rx_sh[7:1] == dev_addr || rx_sh == 8'h00) begin
                                    sda_oe  <= 1'b1;
                                    st_q    <= ST_ACK;
                                    ph_q    <= PH_PTR;
                                    is_read <= rx_sh[0];
                                    is_gc   <= (rx_sh == 8'h00);
                                    gc_hit  <= 1'b0;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                st_q   <= ST_ACK;
                                if (is_gc) begin
                                    if (ph_q == PH_PTR && rx_sh == GC_RESET)
                                        gc_hit <= 1'b1;
                                    ph_q <= PH_MSB;
                                end else begin
                                    case (ph_q)
                                        PH_PTR: begin ptr_q <= rx_sh; ph_q <= PH_MSB; end
                                        PH_MSB: begin msb_q <= rx_sh; ph_q <= PH_LSB; end
                                        default: begin
                                            wr_stb  <= 1'b1;
                                            wr_word <= {msb_q, rx_sh};
                                            ph_q    <= PH_MSB;
                                        end
                                    endcase
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (gc_hit) begin
                                soft_rst_pulse <= 1'b1;
                                gc_hit         <= 1'b0;
                            end
                            if (is_read) begin
                                st_q   <= ST_TX;
                                tx_sh  <= rd_data[REG_W-1:BYTE_W];
                                sda_oe <= ~rd_data[REG_W-1];
                                rd_lsb <= 1'b1;
                            end else begin
                                st_q   <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt_q == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_MACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                tx_sh  <= next_tx;
                                sda_oe <= ~next_tx[BYTE_W-1];
                                rd_lsb <= ~rd_lsb;
                                cnt_q  <= '0;
                                st_q   <= ST_TX;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (soft_rst_pulse)
                ptr_q <= '0;
        end
    end
endmodule

// File: rtl/i2c_tgt_chk.sv
// Protocol checker for i2c_tgt_gcreset, attached by bind.
// Watches the pins, the state register and the stop flag.
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       soft_rst_pulse,
    input logic       stop_det,
    input tgt_state_t st
);
    a_r2_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    a_r7_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK) |-> !sda_oe);

    a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE) && !sda_oe);

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse);

    a_r9_pulse_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> !scl_i);

    a_r9_pulse_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> ($past(st) == ST_ACK));
endmodule

bind i2c_tgt_gcreset i2c_tgt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .soft_rst_pulse(soft_rst_pulse), .stop_det(stop_det), .st(st_q)
);

// File: tb/sim_i2c_tgt_gcreset.sv
module sim_i2c_tgt_gcreset;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
    logic sda_oe, soft_rst_pulse;
    wire  sda_line = m_sda & ~sda_oe;

    int n_tests = 0, n_fail = 0, pulse_cnt = 0, oe_bad = 0;
    logic oe_prev = 1'b0;
    logic [15:0] mdl [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tgt_gcreset u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .soft_rst_pulse(soft_rst_pulse)
    );

    // Bus monitors: reset pulses, and drive changes while SCL is high (R2).
    always @(posedge clk) begin
        if (soft_rst_pulse) pulse_cnt++;
        if (rst_n && m_scl && (sda_oe !== oe_prev)) oe_bad++;
        oe_prev <= sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rd(input int p);
        return (p < NREG) ? mdl[p] : 16'h0000;
    endfunction

    function automatic logic [6:0] dev7(input logic sel);
        return {6'b100100, sel};
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    // Eight data bits plus the rising half of the ninth clock; SCL left high.
    task automatic send_bits(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0;
        end
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        ack = ~sda_line;
    endtask

    task automatic end_ack();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, ack); end_ack();
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_line}; m_scl = 1'b0;
        end
        m_sda = ~give_ack; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] p, input logic [15:0] d, input string tag);
        logic a;
        bus_start();
        send_byte({dev7(addr_sel), 1'b0}, a); check({tag, " addr ack"}, a, 1);
        send_byte(p, a);          check({tag, " ptr ack"}, a, 1);
        send_byte(d[15:8], a);    check({tag, " msb ack"}, a, 1);
        send_byte(d[7:0], a);     check({tag, " lsb ack"}, a, 1);
        bus_stop();
        if (p < NREG) mdl[p] = d;
    endtask

    // Pointer write, repeated start, two-byte read ending in not-acknowledge.
    task automatic do_read(input logic [7:0] p, output logic [15:0] v);
        logic a;
        logic [7:0] hi, lo;
        bus_start();
        send_byte({dev7(addr_sel), 1'b0}, a);
        send_byte(p, a);
        bus_start();
        send_byte({dev7(addr_sel), 1'b1}, a);
        read_byte(1'b1, hi);
        read_byte(1'b0, lo);
        bus_stop();
        v = {hi, lo};
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [15:0] v;
        logic [7:0] b0, b1, b2;
        int pc0;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < NREG; i++) mdl[i] = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 sda_oe after reset", sda_oe, 0);
        check("R1 pulse after reset", soft_rst_pulse, 0);
        for (int i = 0; i < NREG; i++) begin
            do_read(8'(i), v); check("R1 register reset value", v, 0);
        end

        // R5 R8: directed writes then combined read with repeated start
        do_write(8'd0, 16'hA55A, "R5");
        do_write(8'd3, 16'h1234, "R5");
        do_read(8'd0, v); check("R8 read reg0 via repeated start", v, 16'hA55A);
        do_read(8'd3, v); check("R5 read reg3", v, 16'h1234);

        // R5: two pairs in one transfer, second overwrites same register
        bus_start();
        send_byte({dev7(0), 1'b0}, a);
        send_byte(8'd1, a);
        send_byte(8'h11, a); send_byte(8'h22, a);
        send_byte(8'h33, a); send_byte(8'h44, a);
        check("R5 second pair ack", a, 1);
        bus_stop();
        mdl[1] = 16'h3344;
        do_read(8'd1, v); check("R5 overwrite same register", v, 16'h3344);

        // R5 R6: random writes and reads, pointer 0..5
        for (int k = 0; k < 20; k++) begin
            logic [7:0] p;
            logic [15:0] d;
            p = 8'($urandom_range(0, 5));
            d = 16'($urandom);
            do_write(p, d, "R6");
            p = 8'($urandom_range(0, 5));
            do_read(p, v); check("R6 random readback", v, model_rd(int'(p)));
        end

        // R7: read continues while acked: MSB, LSB, MSB; then released
        do_write(8'd2, 16'hC3E1, "R7");
        bus_start();
        send_byte({dev7(0), 1'b0}, a); send_byte(8'd2, a);
        bus_start();
        send_byte({dev7(0), 1'b1}, a); check("R7 read addr ack", a, 1);
        read_byte(1'b1, b0); read_byte(1'b1, b1); read_byte(1'b0, b2);
        check("R7 first byte msb", b0, 8'hC3);
        check("R7 second byte lsb", b1, 8'hE1);
        check("R7 third byte wraps to msb", b2, 8'hC3);
        check("R7 released after nack", sda_oe, 0);
        bus_stop();
        check("R11 idle after stop", sda_oe, 0);

        // R3: wrong address and 10-bit header are not acknowledged
        bus_start(); send_byte({dev7(1), 1'b0}, a); check("R3 wrong address nack", a, 0);
        send_byte(8'h03, a); check("R3 ignored after nack", a, 0);
        send_byte(8'hFF, a); bus_stop();
        bus_start(); send_byte(8'hF0, a); check("R3 10-bit header nack", a, 0); bus_stop();
        do_read(8'd3, v); check("R3 registers untouched", v, mdl[3]);

        // R4: general call with read bit is not acknowledged
        bus_start(); send_byte(8'h01, a); check("R4 gc read nack", a, 0); bus_stop();

        // R10: general call with another byte: acked, ignored
        pc0 = pulse_cnt;
        bus_start();
        send_byte(8'h00, a); check("R4 gc write ack", a, 1);
        send_byte(8'h05, a); check("R10 gc other byte ack", a, 1);
        send_byte(8'h06, a); check("R10 later 0x06 byte ack", a, 1);
        bus_stop();
        check("R10 no pulse", pulse_cnt, pc0);
        for (int i = 0; i < NREG; i++) begin
            do_read(8'(i), v); check("R10 registers unchanged", v, mdl[i]);
        end

        // R9: general-call reset, pulse after SCL falls at end of ack
        do_write(8'd2, 16'hBEEF, "R9");
        pc0 = pulse_cnt;
        bus_start();
        send_byte(8'h00, a);
        send_bits(8'h06, a); check("R9 reset byte ack", a, 1);
        check("R9 no pulse before ack clock falls", pulse_cnt, pc0);
        end_ack();
        check("R9 exactly one pulse", pulse_cnt, pc0 + 1);
        bus_stop();
        for (int i = 0; i < NREG; i++) mdl[i] = 16'h0000;
        bus_start(); send_byte({dev7(0), 1'b1}, a);
        read_byte(1'b1, b0); read_byte(1'b0, b1); bus_stop();
        check("R9 pointer cleared read", {b0, b1}, 16'h0000);
        for (int i = 0; i < NREG; i++) begin
            do_read(8'(i), v); check("R9 registers cleared", v, 0);
        end

        // R3: strap selects lowest address bit
        addr_sel = 1'b1;
        bus_start(); send_byte({dev7(0), 1'b0}, a); check("R3 strap old address nack", a, 0); bus_stop();
        do_write(8'd1, 16'h5A5A, "R3");
        do_read(8'd1, v); check("R3 strap new address readback", v, 16'h5A5A);

        check("R2 no drive change while SCL high", oe_bad, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule